// File: doc/BRIEF.md
# Fast Output Channel Register Bank

This block holds the output state of a small group of fast general-purpose output channels (eight by default) behind a plain register write port. Software can change the output state in three ways, and may mix them freely. It can overwrite every channel in one word. It can send a single word that carries both a channel select mask and new values. It can send a command word that holds a two-bit opcode for each channel, which sets, clears or flips that channel.

A separate drive-enable mask decides which channels the fast path actually drives. A channel outside that mask shows as undriven at the pin side: its output-enable is low and its data is forced low. Its latched value is kept and comes back once the channel is enabled again. A combinational read port returns the latched output state and the enable mask. Software updates the enable mask by reading it, changing it and writing it back.

Top module: `fastout_bank`

## Requirements
- R1: While reset is asserted, and directly after it is released, the output latch and the drive-enable mask are all zeros, so pin_out and pin_oe are zero.
- R2: A write to address 0 replaces every channel's latched bit with wr_data[NUM_CH-1:0].
- R3: A write to address 1 treats wr_data[NUM_CH-1:0] as a channel mask and wr_data[2*NUM_CH-1:NUM_CH] as values. Each channel whose mask bit is 1 takes its value bit, and every other channel keeps its state.
- R4: A write to address 2 gives channel i the opcode wr_data[2i+1:2i]. Opcode 1 sets the channel, opcode 2 clears it and opcode 3 inverts it.
- R5: In a command write, opcode 0 leaves its channel unchanged. Several channels can receive different opcodes in the same write, and bits above 2*NUM_CH-1 are ignored.
- R6: A write to address 3 replaces the drive-enable mask with wr_data[NUM_CH-1:0]. Reading rd_addr 3 returns the mask, zero-extended.
- R7: Reading rd_addr 4 returns the output latch, zero-extended. Any other read address returns zero.
- R8: pin_oe equals the drive-enable mask. pin_out[i] equals the latched bit when channel i is enabled and is 0 otherwise, and disabling a channel does not change its latched bit.
- R9: With wr_en low, or with a write address of 4 or above, neither the latch nor the enable mask changes.
- R10: Every register update becomes visible on the rising clock edge that samples wr_en high, and not before it. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_addr | input | ADDR_W (3) | Write register select |
| wr_data | input | DATA_W (32) | Write data |
| rd_addr | input | ADDR_W (3) | Read register select |
| rd_data | output | DATA_W (32) | Read data (combinational) |
| pin_out | output | NUM_CH (8) | Gated channel output data |
| pin_oe | output | NUM_CH (8) | Channel output enables |

## Verification
A wrong latch bit shows up at the status read address, and also at pin_out if that channel is enabled, in the cycle that follows the faulty edge. A wrong enable bit shows up at pin_oe and at the enable read address at the same moment. The bench compares the status read, the enable read, pin_out and pin_oe after every write, so any corruption is caught one clock after it happens. A bit that is wrong but hidden by a zero enable is still caught through the status read.

// File: rtl/fastout_pkg.sv
package fastout_pkg;

    typedef enum logic [2:0] {
        REG_DIRECT = 3'd0,
        REG_MASKED = 3'd1,
        REG_CMD    = 3'd2,
        REG_ENABLE = 3'd3,
        REG_STATUS = 3'd4
    } reg_sel_e;

    localparam logic [1:0] OP_KEEP = 2'd0;
    localparam logic [1:0] OP_SET  = 2'd1;
    localparam logic [1:0] OP_CLR  = 2'd2;
    localparam logic [1:0] OP_FLIP = 2'd3;

    typedef struct packed {
        logic direct;
        logic masked;
        logic cmd;
        logic enable;
    } wr_sel_t;

endpackage

// File: rtl/fastout_decode.sv
module fastout_decode
    import fastout_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output wr_sel_t           sel
);

    always_comb begin
        sel = '0;
        if (wr_en) begin
            if (wr_addr == ADDR_W'(REG_DIRECT)) sel.direct = 1'b1;
            if (wr_addr == ADDR_W'(REG_MASKED)) sel.masked = 1'b1;
            if (wr_addr == ADDR_W'(REG_CMD))    sel.cmd    = 1'b1;
            if (wr_addr == ADDR_W'(REG_ENABLE)) sel.enable = 1'b1;
        end
    end

endmodule

// File: rtl/fastout_next.sv
module fastout_next
    import fastout_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 32
) (
    input  wr_sel_t           sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NUM_CH-1:0] latch_q,
    input  logic [NUM_CH-1:0] en_q,
    output logic [NUM_CH-1:0] latch_d,
    output logic [NUM_CH-1:0] en_d
);

    localparam int CMD_W = 2 * NUM_CH;

    typedef struct packed {
        logic [NUM_CH-1:0] latch;
        logic [NUM_CH-1:0] en;
    } next_t;

    logic [NUM_CH-1:0] mask_f;
    logic [NUM_CH-1:0] value_f;
    logic [NUM_CH-1:0] cmd_res;
    next_t             nxt;

    assign mask_f  = wr_data[NUM_CH-1:0];
    assign value_f = wr_data[CMD_W-1:NUM_CH];

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cmd
            logic [1:0] op;
            assign op = wr_data[2*ch +: 2];
            always_comb begin
                case (op)
                    OP_SET:  cmd_res[ch] = 1'b1;
                    OP_CLR:  cmd_res[ch] = 1'b0;
                    OP_FLIP: cmd_res[ch] = ~latch_q[ch];
                    default: cmd_res[ch] = latch_q[ch];
                endcase
            end
        end
        if (DATA_W > CMD_W) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^wr_data[DATA_W-1:CMD_W];
        end
    endgenerate

    always_comb begin
        nxt.latch = latch_q;
        nxt.en    = en_q;
        if (sel.direct) nxt.latch = wr_data[NUM_CH-1:0];
        if (sel.masked) nxt.latch = (latch_q & ~mask_f) | (value_f & mask_f);
        if (sel.cmd)    nxt.latch = cmd_res;
        if (sel.enable) nxt.en    = wr_data[NUM_CH-1:0];
    end

    assign latch_d = nxt.latch;
    assign en_d    = nxt.en;

endmodule

// File: rtl/fastout_gate.sv
module fastout_gate #(
    parameter int NUM_CH = 8
) (
    input  logic [NUM_CH-1:0] latch_q,
    input  logic [NUM_CH-1:0] en_q,
    output logic [NUM_CH-1:0] pin_out,
    output logic [NUM_CH-1:0] pin_oe
);

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_pin
            assign pin_oe[ch]  = en_q[ch];
            assign pin_out[ch] = en_q[ch] ? latch_q[ch] : 1'b0;
        end
    endgenerate

endmodule

// File: rtl/fastout_bank.sv
module fastout_bank
    import fastout_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [NUM_CH-1:0] pin_out,
    output logic [NUM_CH-1:0] pin_oe
);

    typedef struct packed {
        logic [NUM_CH-1:0] latch;
        logic [NUM_CH-1:0] en;
    } state_t;

    wr_sel_t           sel;
    state_t            state_d;
    state_t            state_q;
    logic [NUM_CH-1:0] latch_q;
    logic [NUM_CH-1:0] en_q;
    logic [NUM_CH-1:0] latch_nx;
    logic [NUM_CH-1:0] en_nx;

    assign latch_q = state_q.latch;
    assign en_q    = state_q.en;

    fastout_decode #(.ADDR_W(ADDR_W)) u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .sel     (sel)
    );

    fastout_next #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_next (
        .sel     (sel),
        .wr_data (wr_data),
        .latch_q (latch_q),
        .en_q    (en_q),
        .latch_d (latch_nx),
        .en_d    (en_nx)
    );

    always_comb begin
        state_d.latch = latch_nx;
        state_d.en    = en_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    fastout_gate #(.NUM_CH(NUM_CH)) u_gate (
        .latch_q (latch_q),
        .en_q    (en_q),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(REG_STATUS)) rd_data[NUM_CH-1:0] = latch_q;
        if (rd_addr == ADDR_W'(REG_ENABLE)) rd_data[NUM_CH-1:0] = en_q;
    end

endmodule

// File: rtl/fastout_checker.sv
module fastout_checker #(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [NUM_CH-1:0] latch_q,
    input logic [NUM_CH-1:0] en_q,
    input logic [NUM_CH-1:0] pin_out,
    input logic [NUM_CH-1:0] pin_oe
);

    assert_direct_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(0)) |=> latch_q == $past(wr_data[NUM_CH-1:0]));

    assert_masked_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(1)) |=>
        ((latch_q ^ $past(latch_q)) & ~$past(wr_data[NUM_CH-1:0])) == '0);

    assert_masked_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(1)) |=>
        ((latch_q ^ $past(wr_data[2*NUM_CH-1:NUM_CH])) & $past(wr_data[NUM_CH-1:0])) == '0);

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cmd_chk
            assert_cmd_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_addr == ADDR_W'(2) && wr_data[2*ch +: 2] == 2'd1) |=> latch_q[ch]);
            assert_cmd_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_addr == ADDR_W'(2) && wr_data[2*ch +: 2] == 2'd2) |=> !latch_q[ch]);
            assert_cmd_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_addr == ADDR_W'(2) && wr_data[2*ch +: 2] == 2'd3) |=>
                latch_q[ch] != $past(latch_q[ch]));
            assert_cmd_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_addr == ADDR_W'(2) && wr_data[2*ch +: 2] == 2'd0) |=>
                $stable(latch_q[ch]));
        end
    endgenerate

    assert_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(3)) |=> en_q == $past(wr_data[NUM_CH-1:0]));

    assert_pins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe == en_q) && (pin_out == (latch_q & pin_oe)));

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_addr >= ADDR_W'(4)) |=> ($stable(latch_q) && $stable(en_q)));

endmodule

bind fastout_bank fastout_checker #(
    .NUM_CH(NUM_CH),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .latch_q (latch_q),
    .en_q    (en_q),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
);

// File: tb/tb_fastout_bank.sv
module tb_fastout_bank;

    localparam int NUM_CH = 8;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] rd_data;
    logic [NUM_CH-1:0] pin_out;
    logic [NUM_CH-1:0] pin_oe;

    int n_checks = 0;
    int n_bad = 0;
    logic [NUM_CH-1:0] m_latch = '0;
    logic [NUM_CH-1:0] m_en = '0;

    fastout_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [NUM_CH-1:0] model_cmd(input logic [NUM_CH-1:0] cur,
                                                    input logic [DATA_W-1:0] d);
        logic [NUM_CH-1:0] r = cur;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            case (d[2*ch +: 2])
                2'd1: r[ch] = 1'b1;
                2'd2: r[ch] = 1'b0;
                2'd3: r[ch] = ~cur[ch];
                default: r[ch] = cur[ch];
            endcase
        end
        return r;
    endfunction

    task automatic model_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        logic [NUM_CH-1:0] mk = d[NUM_CH-1:0];
        logic [NUM_CH-1:0] vl = d[2*NUM_CH-1:NUM_CH];
        case (a)
            3'd0: m_latch = d[NUM_CH-1:0];
            3'd1: m_latch = (m_latch & ~mk) | (vl & mk);
            3'd2: m_latch = model_cmd(m_latch, d);
            3'd3: m_en = d[NUM_CH-1:0];
            default: ;
        endcase
    endtask

    task automatic check_all(input string tag);
        rd_addr = 3'd4; #1;
        chk({tag, " status"}, rd_data, {24'd0, m_latch});
        rd_addr = 3'd3; #1;
        chk({tag, " enable"}, rd_data, {24'd0, m_en});
        chk({tag, " pin_out R8"}, {24'd0, pin_out}, {24'd0, m_latch & m_en});
        chk({tag, " pin_oe R8"}, {24'd0, pin_oe}, {24'd0, m_en});
    endtask

    function automatic string tag_of(input logic [ADDR_W-1:0] a);
        case (a)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                            input string tag);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
        check_all(tag);
    endtask

    task automatic idle_cycle(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b0; wr_addr = a; wr_data = d;
        @(negedge clk);
        check_all("R9 idle");
    endtask

    initial begin
        #(20 * 150000);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        // R1: reset values
        #5;
        check_all("R1 in reset");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after reset");
        rd_addr = 3'd0; #1;
        chk("R7 other addr", rd_data, 32'd0);

        do_write(3'd0, 32'hFFFF_00A5, "R2 direct");
        do_write(3'd3, 32'h0000_00FF, "R6 enable all");
        do_write(3'd3, 32'hAB00_000F, "R6 R8 enable low half");
        do_write(3'd1, 32'h0000_FF3C, "R3 masked set");
        do_write(3'd1, 32'h0000_0081, "R3 masked clear ends");
        do_write(3'd2, 32'h0000_0000 | 32'h1 | (32'h2 << 14) | (32'h3 << 6), "R4 mixed ops");
        do_write(3'd2, 32'h0000_FFFF, "R4 toggle all");
        do_write(3'd2, 32'hFFFF_0000, "R5 all keep");
        do_write(3'd2, 32'h0000_9999, "R5 set and clear mix");
        do_write(3'd4, 32'hFFFF_FFFF, "R9 write status");
        do_write(3'd7, 32'h0000_0000, "R9 write addr7");
        idle_cycle(3'd0, 32'h0000_0000);
        do_write(3'd3, 32'h0000_0000, "R8 disable keeps latch");
        do_write(3'd3, 32'h0000_00F0, "R8 re-enable");

        // R10: no change before the sampling edge, change after it
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = {24'd0, ~m_latch};
        rd_addr = 3'd4; #1;
        chk("R10 before edge", rd_data, {24'd0, m_latch});
        @(posedge clk); #1;
        wr_en = 1'b0;
        model_write(3'd0, {24'd0, ~m_latch});
        chk("R10 after edge", rd_data, {24'd0, m_latch});
        @(negedge clk);
        check_all("R10 settled");

        for (int i = 0; i < 400; i++) begin
            logic [ADDR_W-1:0] a = ADDR_W'($urandom_range(0, 7));
            logic [DATA_W-1:0] d = $urandom;
            if ($urandom_range(0, 9) == 0) idle_cycle(a, d);
            else do_write(a, d, {tag_of(a), " random"});
        end

        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule